// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Memory Page-Write Controller

This block is a clock-synchronous model of the control side of a byte-wide, self-timed non-volatile memory with a 15-bit address. A host drives active-low chip-select, output-enable and write-strobe lines, an address and a data bus, all sampled on the system clock. Writes are gathered into a page buffer of up to 64 bytes. A load window restarts with every accepted load. When the window expires, an internal programming phase of fixed length runs, and the buffered bytes are then committed to an internal array.

During programming, a read does not return array contents. It returns a status byte. Bit 7 is the inverse of bit 7 of the most recently loaded byte, and bit 6 flips on every new read. A host can therefore detect completion by polling either bit. The bidirectional data bus is split into an input, an output and an output-enable, which an outer pad ring combines into a tri-state bus.

Top module: `eeprom_page_writer`

## Requirements
- R1: `dq_oe` is 1 in the cycle after `ce_n` and `oe_n` are both sampled low, and 0 otherwise. Outside programming, a read returns the array byte at `addr[MEM_AW-1:0]`.
- R2: A write cycle exists only while `ce_n` and `we_n` are low and `oe_n` is high. With `oe_n` low, no byte is loaded.
- R3: The address is taken in the first cycle in which both strobes are sampled low. The data is the last value sampled while both were still low, so the first strobe to rise ends the cycle.
- R4: A load that begins within `LOAD_WIN` cycles of the previous accepted load start joins the same page and restarts the window.
- R5: Programming starts once the window counter reaches `LOAD_WIN` with no write in progress. It lasts `PROG_CYC` cycles, after which the loaded bytes appear in the array.
- R6: The page number is `addr[14:6]`. A load whose page differs from the first load of the open page is ignored and does not restart the window.
- R7: A second load to the same offset within one page replaces the buffered byte. Offsets not loaded keep their old array contents.
- R8: A read during programming returns bit 7 inverted and bits 5:0 unchanged from the last loaded byte. Once programming ends, reads return the true stored data.
- R9: Bit 6 of the status byte inverts on each new read during programming. Outside programming, the toggle state holds still.
- R10: Write cycles that begin during programming have no effect on the buffer or the array.
- R11: After reset the array is all zero, `dq_oe` is 0 and no page is open.
- R12: All 64 offsets of a page can be loaded in one page operation and are committed together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 15 | Byte address |
| dq_i | input | 8 | Data from the bus |
| dq_o | output | 8 | Read data or status byte |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The assertions assume that the strobes are synchronous to the clock, and that a write cycle stays within the load window so that expiry never falls in the middle of a load. The stimulus changes every input on the falling clock edge and holds each strobe low for at least two cycles. It also spaces page loads well inside `LOAD_WIN` unless a scenario is probing expiry. Status reads are issued only after the window has certainly closed and well before `PROG_CYC` runs out, so each poll falls inside the phase it targets.

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 6,
  parameter int MEM_AW    = 9,
  parameter int LOAD_WIN  = 12500,
  parameter int PROG_CYC  = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);
  localparam int PG_W  = ADDR_W - PAGE_BITS;
  localparam int PG_SZ = 1 << PAGE_BITS;
  localparam int DEPTH = 1 << MEM_AW;
  localparam int WIN_W = $clog2(LOAD_WIN + 1);
  localparam int PRG_W = $clog2(PROG_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_MAX  = WIN_W'(LOAD_WIN);
  localparam logic [PRG_W-1:0] PRG_LAST = PRG_W'(PROG_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} st_t;

  st_t                 st;
  logic                wr_act_q, rd_act_q, acc_q, tog;
  logic [PG_W-1:0]     page_q;
  logic [PAGE_BITS-1:0] off_q;
  logic [DATA_W-1:0]   d_hold, last_d;
  logic [WIN_W-1:0]    win_cnt;
  logic [PRG_W-1:0]    prg_cnt;
  logic [PG_SZ-1:0]    vmask;
  logic [DATA_W-1:0]   pbuf [PG_SZ];
  logic [DATA_W-1:0]   mem  [DEPTH];

  wire wr_act    = !ce_n && !we_n && oe_n;
  wire rd_act    = !ce_n && !oe_n;
  wire wr_start  = wr_act && !wr_act_q;
  wire wr_end    = !wr_act && wr_act_q;
  wire rd_start  = rd_act && !rd_act_q;
  wire [PG_W-1:0] in_page = addr[ADDR_W-1:PAGE_BITS];
  wire accept    = wr_start && (st == S_IDLE || (st == S_LOAD && in_page == page_q));
  wire win_done  = st == S_LOAD && win_cnt == WIN_MAX && !wr_act && !wr_act_q;
  wire prog_done = st == S_PROG && prg_cnt == PRG_LAST;
  wire tog_nxt   = (st == S_PROG && rd_start) ? ~tog : tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      acc_q    <= 1'b0;
      tog      <= 1'b0;
      page_q   <= '0;
      off_q    <= '0;
      d_hold   <= '0;
      last_d   <= '0;
      win_cnt  <= '0;
      prg_cnt  <= '0;
      vmask    <= '0;
      dq_o     <= '0;
      dq_oe    <= 1'b0;
      for (int i = 0; i < PG_SZ; i++) pbuf[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      tog      <= tog_nxt;
      if (wr_act) d_hold <= dq_i;

      if (accept) begin
        page_q  <= in_page;
        off_q   <= addr[PAGE_BITS-1:0];
        acc_q   <= 1'b1;
        win_cnt <= '0;
        if (st == S_IDLE) st <= S_LOAD;
      end else if (st == S_LOAD && win_cnt != WIN_MAX) begin
        win_cnt <= win_cnt + 1'b1;
      end

      if (wr_end && acc_q) begin
        pbuf[off_q]  <= d_hold;
        vmask[off_q] <= 1'b1;
        last_d       <= d_hold;
        acc_q        <= 1'b0;
      end

      if (win_done) begin
        st      <= S_PROG;
        prg_cnt <= '0;
      end

      if (st == S_PROG) begin
        if (prog_done) begin
          for (int i = 0; i < PG_SZ; i++)
            if (vmask[i]) mem[MEM_AW'({page_q, PAGE_BITS'(i)})] <= pbuf[i];
          vmask <= '0;
          st    <= S_IDLE;
        end else begin
          prg_cnt <= prg_cnt + 1'b1;
        end
      end

      dq_oe <= rd_act;
      dq_o  <= (st == S_PROG) ? {~last_d[DATA_W-1], tog_nxt, last_d[DATA_W-3:0]}
                              : mem[addr[MEM_AW-1:0]];
    end
  end

  assert_bus_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> $past(!ce_n && !oe_n));

  assert_prog_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG && $past(st == S_LOAD)) |-> $past(win_cnt == WIN_MAX && !wr_act));

  assert_page_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && $past(st == S_LOAD)) |-> $stable(page_q));

  assert_status_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(st == S_PROG)) |-> (dq_o[DATA_W-1] != last_d[DATA_W-1]));

  assert_toggle_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_PROG && $past(st != S_PROG)) |-> $stable(tog));

  assert_mask_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG && $past(st == S_PROG)) |-> $stable(vmask));

  assert_no_load_in_prog_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROG) |-> !acc_q);
endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
  localparam int WIN = 20;
  localparam int PRG = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  dq_i = '0;
  logic [7:0]  dq_o;
  logic        dq_oe;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  eeprom_page_writer #(.LOAD_WIN(WIN), .PROG_CYC(PRG), .MEM_AW(9)) i_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_we(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; dq_i = d; oe_n = 1'b1; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    idle(2);
    we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(input logic [14:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    idle(2);
    v = dq_o; oe = dq_oe;
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle();
    idle(WIN + PRG + 10);
  endtask

  task automatic expect_byte(input logic [14:0] a, input logic [7:0] e, input string tag);
    logic [7:0] v; logic oe;
    rd(a, v, oe);
    chk(v == e && oe, tag, {23'd0, oe, v}, {24'd1, e});
  endtask

  task automatic t_reset();
    chk(dq_oe == 1'b0, "R11 bus released after reset", dq_oe, 0);
    expect_byte(15'h0123, 8'h00, "R11 array cleared / R1 read");
  endtask

  task automatic t_select_gates_read();
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
    idle(3);
    chk(dq_oe == 1'b0, "R1 no drive while ce_n high", dq_oe, 0);
    oe_n = 1'b1; ce_n = 1'b0;
    idle(3);
    chk(dq_oe == 1'b0, "R1 no drive while oe_n high", dq_oe, 0);
    ce_n = 1'b1;
    idle(2);
  endtask

  task automatic t_single_poll();
    logic [7:0] v1, v2, v3; logic oe;
    wr_we(15'h0045, 8'h3A);
    idle(WIN + 3);
    rd(15'h0045, v1, oe);
    chk((v1 & 8'hBF) == 8'hBA, "R8 status bit7 inverted, low bits kept", v1 & 8'hBF, 8'hBA);
    rd(15'h0045, v2, oe);
    chk(v2[6] != v1[6], "R9 bit6 flips on second read", v2[6], ~v1[6]);
    rd(15'h0045, v3, oe);
    chk(v3[6] != v2[6], "R9 bit6 flips on third read", v3[6], ~v2[6]);
    idle(PRG);
    rd(15'h0045, v1, oe);
    chk(v1 == 8'h3A, "R8 true data after programming", v1, 8'h3A);
    rd(15'h0045, v2, oe);
    chk(v2 == v1, "R9 no toggling once idle", v2, v1);
  endtask

  task automatic t_page_mix();
    wr_we(15'h0081, 8'h11);
    wr_we(15'h0085, 8'h55);
    wr_we(15'h0081, 8'h77);
    wr_we(15'h00C3, 8'h99);
    settle();
    expect_byte(15'h0081, 8'h77, "R7 repeated load overwrites");
    expect_byte(15'h0085, 8'h55, "R7 second offset committed");
    expect_byte(15'h0082, 8'h00, "R7 unloaded offset untouched");
    expect_byte(15'h00C3, 8'h00, "R6 other page load ignored");
  endtask

  task automatic t_window();
    logic [7:0] v; logic oe;
    wr_we(15'h0100, 8'hA1);
    idle(WIN - 8);
    wr_we(15'h0102, 8'hA2);
    idle(WIN - 8);
    wr_we(15'h0104, 8'hA3);
    idle(WIN + 3);
    rd(15'h0104, v, oe);
    chk(v[7] == 1'b0, "R5 automatic programming after window", v[7], 0);
    settle();
    expect_byte(15'h0100, 8'hA1, "R4 first load kept");
    expect_byte(15'h0102, 8'hA2, "R4 load inside window joins page");
    expect_byte(15'h0104, 8'hA3, "R4 retriggered window load");
  endtask

  task automatic t_ce_ctrl();
    @(negedge clk); we_n = 1'b0; oe_n = 1'b1; addr = 15'h0140; dq_i = 8'h11;
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); addr = 15'h0141; dq_i = 8'h5C;
    idle(2);
    ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1; dq_i = 8'hFF;
    settle();
    expect_byte(15'h0140, 8'h5C, "R3 address from start, data from end");
    expect_byte(15'h0141, 8'h00, "R3 later address not used");
  endtask

  task automatic t_oe_blocks();
    @(negedge clk); addr = 15'h0180; dq_i = 8'h66; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    idle(3);
    ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1; oe_n = 1'b1;
    settle();
    expect_byte(15'h0180, 8'h00, "R2 no write with oe_n low");
  endtask

  task automatic t_busy_ignore();
    wr_we(15'h01C0, 8'h21);
    idle(WIN + 3);
    wr_we(15'h01C1, 8'h42);
    wr_we(15'h01C0, 8'h99);
    settle();
    expect_byte(15'h01C0, 8'h21, "R10 write during programming ignored");
    expect_byte(15'h01C1, 8'h00, "R10 new offset during programming ignored");
  endtask

  task automatic t_full_page();
    int bad = 0;
    for (int i = 0; i < 64; i++) wr_we(15'h7E00 + 15'(i), 8'(i) ^ 8'h5A);
    wr_we(15'h3E05, 8'hEE);
    settle();
    for (int i = 0; i < 64; i++) begin
      logic [7:0] v; logic oe;
      rd(15'h7E00 + 15'(i), v, oe);
      chk(v == (8'(i) ^ 8'h5A), "R12 full page byte", v, 8'(i) ^ 8'h5A);
    end
    expect_byte(15'h0005, 8'h5F, "R6 high page bits compared");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_select_gates_read();
    t_single_poll();
    t_page_mix();
    t_window();
    t_ce_ctrl();
    t_oe_blocks();
    t_busy_ignore();
    t_full_page();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule